// File: doc/BRIEF.md
# One-Time Fuse Program and Read Controller

This block stores a small array of one-time-programmable bits and serves program and read commands against it. Each row holds 32 bits. A bit can only change from 0 to 1. Before a bit is burned, the block decides whether the bit is write-protected. Four things can protect it: a global program enable, a sticky software lock, a fixed table that ties row ranges to lock bits, and those lock bits themselves, which live in the same array. Reads of the rows that hold secret keys are refused and return zero.

Commands arrive on two valid/ready channels, one for program and one for read. The program channel is always ready. The read channel is back-pressured for any cycle in which a program command is valid, so a program is never delayed by a read. A back-pressured read must hold its valid and address until the cycle in which ready is high.

Every outcome is reported as a sticky flag to an external interrupt block. That block clears the flags through a per-flag clear strobe. There are two reset inputs. A power-on reset clears the array. A soft reset clears the flags and the software lock, forces the anchor bits, and keeps the stored fuse contents.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: A command address packs the column in bits 4:0, the row in bits 12:5 and the page in bits 16:13; the read channel ignores bits 4:0. pgm_ready is always 1. rd_ready is 0 in every cycle in which pgm_valid is 1.
- R2: An accepted program to an existing page and row that is not locked sets that bit to 1. Programming a bit that is already 1 succeeds. The array is cleared only by por_n and keeps its contents across rst_n.
- R3: When pgm_en is 0, every program is refused.
- R4: A pulse on sw_lock_set sets a software lock that stays set until rst_n. While it is set, programs to page 0 rows 44 to 51 are refused.
- R5: On page 0, a program is refused when the lock bit in page 0 row 43 for the target row is 1. The lock columns are: row 4 uses column 31, rows 8 to 11 use column 27, rows 12 to 19 use column 11, rows 20 to 27 use column 13, rows 28 to 35 use column 15, row 37 uses column 28, rows 64 to 71 use column 6, rows 72 to 79 use column 7, and rows 80 to 87 use column 8.
- R6: On page 2, the bits from row 129 column 0 up to row 255 column 27 are refused when page 0 row 43 column 16 is 1. Every other bit of page 2, and every bit of any other page, is free of row locks.
- R7: One cycle after an accepted program, pgm_done is 1. pgm_err is also set when the program was refused or its page or row does not exist. Each flag is cleared only by rst_n or by its flag_clr bit (bit 0 clears pgm_done, bit 1 pgm_err, bit 2 rd_done, bit 3 rd_err). A set in the same cycle as a clear wins.
- R8: One cycle after an accepted read, rd_data holds the addressed row and rd_done is 1. A read of page 0 rows 12 to 35, or of a page or row that does not exist, returns 0 and sets rd_err.
- R9: tbit_ok bit p is 1 when columns 28 to 31 of row 0 on page p are all 1. The status is refreshed two cycles after an accepted program to row 0 at column 28 or above, two cycles after a cache_load pulse, and on leaving soft reset.
- R10: While rst_n is low, row 0 columns 1 and 27 are forced to 1 on every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the fuse array |
| rst_n | input | 1 | Soft reset, active low |
| pgm_en | input | 1 | Global program enable |
| sw_lock_set | input | 1 | Pulse that sets the sticky software lock |
| pgm_valid | input | 1 | Program command valid |
| pgm_ready | output | 1 | Program command ready (constant 1) |
| pgm_addr | input | 17 | Program address {page, row, column} |
| rd_valid | input | 1 | Read command valid |
| rd_ready | output | 1 | Read command ready |
| rd_addr | input | 17 | Read address {page, row, unused} |
| rd_data | output | 32 | Data of the last read row |
| cache_load | input | 1 | Pulse that requests a test-bit status refresh |
| flag_clr | input | 4 | Per-flag clear strobes |
| pgm_done | output | 1 | Sticky program-done flag |
| pgm_err | output | 1 | Sticky program-error flag |
| rd_done | output | 1 | Sticky read-done flag |
| rd_err | output | 1 | Sticky read-error flag |
| tbit_ok | output | NUM_PAGES | Per-page test-bit status |

## Verification
Two pairs of actions can fall into the same cycle. The first pair is a program and a read. The bench raises both valids on the same clock. It then expects only pgm_done to be set, and expects the held read to complete one cycle later. The second pair is a flag being set and the same flag being cleared. The bench pulses flag_clr bit 0 on the very edge at which a program is accepted, and judges the result by pgm_done staying at 1. Around these cases, sweeps run over whole row ranges of page 0 and page 2 with the lock bits clear and then set. The expected error and read-back values come from a model of the lock table and the array that the bench keeps itself.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int COL_W   = 5;
  localparam int ROW_W   = 8;
  localparam int PAGE_W  = 4;
  localparam int ADDR_W  = COL_W + ROW_W + PAGE_W;
  localparam int WORD_W  = 32;

  localparam int LOCK_ROW      = 43;
  localparam int SWL_FIRST     = 44;
  localparam int SWL_LAST      = 51;
  localparam int KEY_RD_FIRST  = 12;
  localparam int KEY_RD_LAST   = 35;
  localparam int SYN_PAGE      = 2;
  localparam int SYN_ROW_FIRST = 129;
  localparam int SYN_ROW_LAST  = 255;
  localparam int SYN_COL_LAST  = 27;
  localparam int SYN_LOCK_COL  = 16;
  localparam int TBIT_COL      = 28;
  localparam int ANCHOR_LO     = 1;
  localparam int ANCHOR_HI     = 27;

  typedef struct packed {
    logic             hit;
    logic [COL_W-1:0] col;
  } lock_ref_t;

  // Row-to-lock-column table for page 0
  function automatic lock_ref_t row_lock_ref(input logic [ROW_W-1:0] row);
    lock_ref_t r;
    int unsigned n;
    n = int'(row);
    r.hit = 1'b1;
    if (n == 4)                     r.col = 5'd31;
    else if (n >= 8  && n <= 11)    r.col = 5'd27;
    else if (n >= 12 && n <= 19)    r.col = 5'd11;
    else if (n >= 20 && n <= 27)    r.col = 5'd13;
    else if (n >= 28 && n <= 35)    r.col = 5'd15;
    else if (n == 37)               r.col = 5'd28;
    else if (n >= 64 && n <= 87)    r.col = COL_W'(6 + (n - 64) / 8);
    else begin
      r.hit = 1'b0;
      r.col = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/otp_lock_eval.sv
module otp_lock_eval
  import otp_pkg::*;
(
  input  logic              pgm_en,
  input  logic              sw_lock,
  input  logic [PAGE_W-1:0] page,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [WORD_W-1:0] lock_word,
  output logic              locked
);
  lock_ref_t ref_q;
  logic      in_swl, in_syn;

  always_comb begin
    ref_q  = row_lock_ref(row);
    in_swl = (int'(row) >= SWL_FIRST) && (int'(row) <= SWL_LAST);
    in_syn = (int'(row) >= SYN_ROW_FIRST) &&
             ((int'(row) < SYN_ROW_LAST) || (int'(col) <= SYN_COL_LAST));
    locked = 1'b0;
    if (!pgm_en) begin
      locked = 1'b1;
    end else if (page == '0) begin
      if (sw_lock && in_swl)  locked = 1'b1;
      else if (ref_q.hit)     locked = lock_word[ref_q.col];
    end else if (int'(page) == SYN_PAGE) begin
      if (in_syn)             locked = lock_word[SYN_LOCK_COL];
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int NUM_PAGES = 3,
  parameter int NUM_ROWS  = 256,
  localparam int NWORDS   = NUM_PAGES * NUM_ROWS,
  localparam int IDX_W    = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] lock_word,
  output logic [NUM_PAGES-1:0] tbit_vec
);
  logic [WORD_W-1:0] mem [NWORDS];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        mem[p*NUM_ROWS][ANCHOR_LO] <= 1'b1;
        mem[p*NUM_ROWS][ANCHOR_HI] <= 1'b1;
      end
    end else if (wr_en) begin
      mem[wr_idx][wr_col] <= 1'b1;
    end
  end

  assign rd_word   = mem[rd_idx];
  assign lock_word = mem[LOCK_ROW];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_tbit
    assign tbit_vec[p] = &mem[p*NUM_ROWS][WORD_W-1:TBIT_COL];
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_PAGES = 3,
  parameter int NUM_ROWS  = 256
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  rst_n,
  input  logic                  pgm_en,
  input  logic                  sw_lock_set,
  input  logic                  pgm_valid,
  output logic                  pgm_ready,
  input  logic [16:0]           pgm_addr,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [16:0]           rd_addr,
  output logic [31:0]           rd_data,
  input  logic                  cache_load,
  input  logic [3:0]            flag_clr,
  output logic                  pgm_done,
  output logic                  pgm_err,
  output logic                  rd_done,
  output logic                  rd_err,
  output logic [NUM_PAGES-1:0]  tbit_ok
);
  localparam int NWORDS = NUM_PAGES * NUM_ROWS;
  localparam int IDX_W  = $clog2(NWORDS);

  logic [PAGE_W-1:0] p_page, r_page;
  logic [ROW_W-1:0]  p_row, r_row;
  logic [COL_W-1:0]  p_col;
  logic              p_exists, r_exists, r_key;
  logic [IDX_W-1:0]  p_idx, r_idx;
  logic              pgm_fire, rd_fire, locked, wr_ok, tbit_hit;
  logic              sw_lock, refresh_q;
  logic [WORD_W-1:0] rd_word, lock_word;
  logic [NUM_PAGES-1:0] tbit_vec;

  assign {p_page, p_row, p_col} = pgm_addr;
  assign {r_page, r_row}        = rd_addr[ADDR_W-1:COL_W];

  assign pgm_ready = 1'b1;
  assign rd_ready  = !pgm_valid;
  assign pgm_fire  = pgm_valid && pgm_ready;
  assign rd_fire   = rd_valid && rd_ready;

  always_comb begin
    p_exists = (int'(p_page) < NUM_PAGES) && (int'(p_row) < NUM_ROWS);
    r_exists = (int'(r_page) < NUM_PAGES) && (int'(r_row) < NUM_ROWS);
    p_idx = p_exists ? IDX_W'(int'(p_page) * NUM_ROWS + int'(p_row)) : '0;
    r_idx = r_exists ? IDX_W'(int'(r_page) * NUM_ROWS + int'(r_row)) : '0;
    r_key = (r_page == '0) && (int'(r_row) >= KEY_RD_FIRST) &&
            (int'(r_row) <= KEY_RD_LAST);
    tbit_hit = (p_row == '0) && (int'(p_col) >= TBIT_COL);
  end

  otp_lock_eval u_lock (
    .pgm_en    (pgm_en),
    .sw_lock   (sw_lock),
    .page      (p_page),
    .row       (p_row),
    .col       (p_col),
    .lock_word (lock_word),
    .locked    (locked)
  );

  assign wr_ok = pgm_fire && p_exists && !locked;

  otp_fuse_array #(.NUM_PAGES(NUM_PAGES), .NUM_ROWS(NUM_ROWS)) u_array (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .wr_en     (wr_ok),
    .wr_idx    (p_idx),
    .wr_col    (p_col),
    .rd_idx    (r_idx),
    .rd_word   (rd_word),
    .lock_word (lock_word),
    .tbit_vec  (tbit_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_lock   <= 1'b0;
      refresh_q <= 1'b1;
      tbit_ok   <= '0;
      rd_data   <= '0;
      pgm_done  <= 1'b0;
      pgm_err   <= 1'b0;
      rd_done   <= 1'b0;
      rd_err    <= 1'b0;
    end else begin
      if (sw_lock_set) sw_lock <= 1'b1;
      refresh_q <= cache_load || (wr_ok && tbit_hit);
      if (refresh_q) tbit_ok <= tbit_vec;
      if (rd_fire) rd_data <= (r_exists && !r_key) ? rd_word : '0;
      pgm_done <= (pgm_done && !flag_clr[0]) || pgm_fire;
      pgm_err  <= (pgm_err  && !flag_clr[1]) || (pgm_fire && !wr_ok);
      rd_done  <= (rd_done  && !flag_clr[2]) || rd_fire;
      rd_err   <= (rd_err   && !flag_clr[3]) || (rd_fire && (r_key || !r_exists));
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int NUM_PAGES = 3
) (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        pgm_en,
  input logic        pgm_valid,
  input logic        pgm_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [16:0] rd_addr,
  input logic [31:0] rd_data,
  input logic [3:0]  flag_clr,
  input logic        pgm_done,
  input logic        pgm_err,
  input logic        rd_done,
  input logic        rd_err
);
  // R1: a valid program always blocks the read channel
  p_rd_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pgm_valid |-> !rd_ready);

  // R3: disabled programming always ends in an error flag
  p_pgm_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pgm_valid && pgm_ready && !pgm_en) |=> pgm_err);

  // R7: a done flag only rises after an accepted program
  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(pgm_done) |-> $past(pgm_valid && pgm_ready));

  // R7: an error flag holds until it is cleared
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pgm_err && !flag_clr[1]) |=> pgm_err);

  // R8: a key row read is refused with zero data
  p_key_denied_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_valid && rd_ready && rd_addr[16:13] == 4'd0 &&
     rd_addr[12:5] >= 8'd12 && rd_addr[12:5] <= 8'd35) |=> (rd_err && rd_data == 32'd0));

  // R8: every accepted read sets the done flag
  p_rd_done_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_valid && rd_ready) |=> rd_done);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .pgm_en    (pgm_en),
  .pgm_valid (pgm_valid),
  .pgm_ready (pgm_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .flag_clr  (flag_clr),
  .pgm_done  (pgm_done),
  .pgm_err   (pgm_err),
  .rd_done   (rd_done),
  .rd_err    (rd_err)
);

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;
  localparam int NP = 3;
  localparam int NR = 256;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        pgm_en = 1'b0, sw_lock_set = 1'b0;
  logic        pgm_valid = 1'b0, rd_valid = 1'b0, cache_load = 1'b0;
  logic [16:0] pgm_addr = '0, rd_addr = '0;
  logic [3:0]  flag_clr = '0;
  logic        pgm_ready, rd_ready, pgm_done, pgm_err, rd_done, rd_err;
  logic [31:0] rd_data;
  logic [NP-1:0] tbit_ok;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] model [NP][NR];

  always #4 clk = ~clk;

  otp_fuse_ctrl #(.NUM_PAGES(NP), .NUM_ROWS(NR)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pgm_en(pgm_en),
    .sw_lock_set(sw_lock_set), .pgm_valid(pgm_valid), .pgm_ready(pgm_ready),
    .pgm_addr(pgm_addr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .cache_load(cache_load),
    .flag_clr(flag_clr), .pgm_done(pgm_done), .pgm_err(pgm_err),
    .rd_done(rd_done), .rd_err(rd_err), .tbit_ok(tbit_ok)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // page-0 lock column per the requirement table, -1 when none
  function automatic int lock_col(input int row);
    if (row == 4) return 31;
    if (row >= 8 && row <= 11) return 27;
    if (row >= 12 && row <= 19) return 11;
    if (row >= 20 && row <= 27) return 13;
    if (row >= 28 && row <= 35) return 15;
    if (row == 37) return 28;
    if (row >= 64 && row <= 87) return 6 + (row - 64) / 8;
    return -1;
  endfunction

  function automatic bit exp_locked(input int pg, input int row, input int col, input bit swl);
    if (pg >= NP) return 1;
    if (pg == 0) begin
      if (swl && row >= 44 && row <= 51) return 1;
      if (lock_col(row) >= 0) return model[0][43][lock_col(row)];
      return 0;
    end
    if (pg == 2 && row >= 129 && (row < 255 || col <= 27)) return model[0][43][16];
    return 0;
  endfunction

  task automatic clear_flags();
    @(negedge clk); flag_clr = 4'hF;
    @(negedge clk); flag_clr = 4'h0;
  endtask

  task automatic pgm(input int pg, input int row, input int col, input bit exp_err, input string tag);
    clear_flags();
    pgm_addr = {4'(pg), 8'(row), 5'(col)};
    pgm_valid = 1'b1;
    @(negedge clk); pgm_valid = 1'b0;
    chk(pgm_done == 1'b1, {tag, " done"}, pgm_done, 1);
    chk(pgm_err == exp_err, {tag, " err"}, pgm_err, exp_err);
    if (!exp_err && pg < NP) model[pg][row][col] = 1'b1;
  endtask

  task automatic rd(input int pg, input int row, input bit exp_err, input logic [31:0] exp_data, input string tag);
    clear_flags();
    rd_addr = {4'(pg), 8'(row), 5'h1F};
    rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk(rd_done == 1'b1, {tag, " rd_done"}, rd_done, 1);
    chk(rd_err == exp_err, {tag, " rd_err"}, rd_err, exp_err);
    chk(rd_data == exp_data, {tag, " data"}, rd_data, exp_data);
  endtask

  function automatic logic [31:0] exp_rd(input int pg, input int row);
    if (pg == 0 && row >= 12 && row <= 35) return 32'd0;
    return model[pg][row];
  endfunction

  function automatic bit key_row(input int pg, input int row);
    return pg == 0 && row >= 12 && row <= 35;
  endfunction

  task automatic soft_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) model[p][r] = '0;
    for (int p = 0; p < NP; p++) model[p][0] = 32'h0800_0002;

    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk({pgm_done, pgm_err, rd_done, rd_err} == 4'b0, "R7 reset flags", {pgm_done, pgm_err, rd_done, rd_err}, 0);
    chk(tbit_ok == '0, "R9 reset tbit", tbit_ok, 0);
    chk(pgm_ready == 1'b1, "R1 pgm_ready", pgm_ready, 1);
    for (int p = 0; p < NP; p++) rd(p, 0, 0, 32'h0800_0002, "R10 anchors");

    // global disable
    pgm(1, 5, 3, 1, "R3 disabled");
    rd(1, 5, 0, 32'd0, "R3 untouched");
    pgm_en = 1'b1;

    // sweep with no locks set
    for (int r = 0; r < 88; r++)
      if (r != 43) pgm(0, r, r % 32, 0, "R2 sweep open");
    pgm(2, 200, 0, 0, "R6 page2 open");
    pgm(0, 0, 1, 0, "R2 already set");
    foreach (model[0][43][c]) ;
    begin
      int cols [10] = '{31, 27, 11, 13, 15, 28, 6, 7, 8, 16};
      foreach (cols[i]) pgm(0, 43, cols[i], 0, "R5 arm locks");
    end
    rd(0, 43, 0, model[0][43], "R5 lock row");

    // sweep with row locks armed
    for (int r = 0; r < 88; r++)
      if (r != 43) pgm(0, r, (r + 5) % 32, exp_locked(0, r, (r + 5) % 32, 0), "R5 sweep locked");

    // software lock
    @(negedge clk); sw_lock_set = 1'b1;
    @(negedge clk); sw_lock_set = 1'b0;
    for (int r = 40; r < 56; r++)
      if (r != 43) pgm(0, r, (r + 9) % 32, exp_locked(0, r, (r + 9) % 32, 1), "R4 sw lock");

    // page 2 protected region and other pages
    begin
      int rows [6] = '{127, 128, 129, 200, 255, 255};
      int cls  [6] = '{27, 27, 0, 27, 27, 28};
      foreach (rows[i]) pgm(2, rows[i], cls[i], exp_locked(2, rows[i], cls[i], 1), "R6 page2");
    end
    pgm(2, 255, 31, 0, "R6 page2 tail");
    pgm(1, 200, 3, 0, "R6 page1 free");

    // missing page
    pgm(3, 1, 1, 1, "R7 bad page");
    pgm(15, 0, 0, 1, "R7 bad page 15");
    rd(3, 1, 1, 32'd0, "R8 bad page");

    // read sweeps
    for (int r = 0; r < NR; r++) rd(0, r, key_row(0, r), exp_rd(0, r), "R8 sweep p0");
    for (int r = 120; r < NR; r++) rd(2, r, 0, exp_rd(2, r), "R8 sweep p2");

    // test bits
    for (int c = 28; c < 31; c++) pgm(1, 0, c, 0, "R9 tbit partial");
    @(negedge clk);
    chk(tbit_ok == 3'b000, "R9 partial", tbit_ok, 0);
    pgm(1, 0, 31, 0, "R9 tbit full");
    chk(tbit_ok == 3'b000, "R9 not yet", tbit_ok, 0);
    @(negedge clk);
    chk(tbit_ok == 3'b010, "R9 refreshed", tbit_ok, 3'b010);
    @(negedge clk); cache_load = 1'b1;
    @(negedge clk); cache_load = 1'b0;
    @(negedge clk);
    chk(tbit_ok == 3'b010, "R9 cache load", tbit_ok, 3'b010);

    // collisions
    clear_flags();
    pgm_addr = {4'd1, 8'd7, 5'd2}; pgm_valid = 1'b1;
    rd_addr = {4'd1, 8'd7, 5'd0};  rd_valid = 1'b1;
    #1 chk(rd_ready == 1'b0, "R1 rd blocked", rd_ready, 0);
    @(negedge clk); pgm_valid = 1'b0; model[1][7][2] = 1'b1;
    chk(pgm_done == 1'b1 && rd_done == 1'b0, "R1 pgm first", {pgm_done, rd_done}, 2'b10);
    @(negedge clk); rd_valid = 1'b0;
    chk(rd_done == 1'b1 && rd_data == model[1][7], "R1 rd after", rd_data, model[1][7]);
    @(negedge clk); flag_clr = 4'b0001;
    pgm_addr = {4'd1, 8'd8, 5'd2}; pgm_valid = 1'b1;
    @(negedge clk); pgm_valid = 1'b0; flag_clr = 4'b0; model[1][8][2] = 1'b1;
    chk(pgm_done == 1'b1, "R7 set beats clear", pgm_done, 1);
    @(negedge clk); flag_clr = 4'b0001;
    @(negedge clk); flag_clr = 4'b0;
    chk(pgm_done == 1'b0, "R7 cleared", pgm_done, 0);

    // soft reset keeps fuses, drops software lock
    soft_reset();
    chk({pgm_done, pgm_err, rd_done, rd_err} == 4'b0, "R7 soft reset flags", {pgm_done, pgm_err, rd_done, rd_err}, 0);
    chk(tbit_ok == 3'b010, "R9 after soft reset", tbit_ok, 3'b010);
    rd(1, 0, 0, model[1][0], "R2 survives");
    pgm(0, 44, 30, 0, "R4 lock cleared");
    rd(0, 44, 0, model[0][44], "R2 row 44");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule